// File: doc/BRIEF.md
# Dual Odd/Even Clock Divider

This block derives two divided clocks from one reference clock of roughly 13 MHz. Each output has its own 8-bit divisor. Even and odd ratios are both accepted, and in every case the output is high for exactly half of its period. Odd ratios reach this by also using the falling edge of the reference. With a 13 MHz reference, the reset ratios of 15 and 46 give about 866.67 kHz and 282.6 kHz.

Both divisor bytes are captured on a single load strobe. A captured value is held as pending and replaces the running divisor only when the next output period begins. The period in progress always finishes at its old length, so no runt pulse can appear. A divisor of 0 or 1 makes the output copy the reference clock. The two channels share only the reference, the reset and the strobe, and each runs on its own divisor.

Top module: `dual_clk_divider`

## Requirements
- R1: While reset (active low) is asserted, both outputs are low. Out of reset the divisors are 15 for output A and 46 for output B. Each output goes high on the first rising reference edge after reset is released.
- R2: For an even divisor N of 2 or more, the output period is N reference cycles. The output is high for the first N/2 cycles of each period and low for the rest.
- R3: For an odd divisor N of 3 or more, the output period is N reference cycles. The output is high for exactly N/2 cycles: (N-1)/2 whole cycles plus one half cycle that ends at a falling reference edge.
- R4: A rising reference edge with the load strobe high captures both divisor bytes as pending values. A later strobe overwrites an earlier value that has not yet been applied.
- R5: A pending divisor is applied at the first output period start that follows its capture, including a start on the same edge as the capture. The period in progress finishes at the old length.
- R6: A divisor of 0 or 1 drives the output from the reference clock itself. Leaving that mode takes effect at the next rising reference edge.
- R7: The timing of each output depends only on its own divisor. Changing one divisor does not disturb the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStrobe | input | 1 | Captures divA and divB on a rising refClk edge |
| divA | input | 8 | Divisor for output A |
| divB | input | 8 | Divisor for output B |
| outA | output | 1 | Divided clock A |
| outB | output | 1 | Divided clock B |

## Verification
The hardest case to reach is a divisor change in the middle of a period. This includes a strobe that lands on the last cycle of a period, and a second strobe that overwrites a pending value before it is used. The stimulus issues loads at chosen offsets inside long periods (46 and 15), and back-to-back loads while a short ratio is running. It also switches between pass-through and dividing modes in both directions. The reference model tracks each output in half-cycle steps, so the extra half cycle of an odd ratio is checked after every rising and every falling edge.

// File: rtl/div_pkg.sv
package div_pkg;
  // Strobes from the counter control to the output datapath, valid for the next rising edge
  typedef struct packed {
    logic riseNext;    // rising-edge phase is high in the coming cycle
    logic oddNext;     // divisor in force for the coming cycle is odd
    logic bypassNext;  // divisor in force is 0 or 1
  } div_ctl_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl import div_pkg::*; #(
  parameter int W   = 8,
  parameter int DEF = 15
) (
  input  logic         refClk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] newDiv,
  output div_ctl_t     ctl
);
  localparam logic [W-1:0] DefVal  = W'(DEF);
  localparam logic [W-1:0] DefLast = W'(DEF - 1);
  localparam logic [W-1:0] Two     = W'(2);

  logic [W-1:0] cnt, active, pending;
  logic [W-1:0] pendingN, cntN, activeN;
  logic         terminal;

  always_comb begin
    pendingN = load ? newDiv : pending;
    terminal = (active < Two) || (cnt == active - 1'b1);
    cntN     = terminal ? '0 : cnt + 1'b1;
    activeN  = terminal ? pendingN : active;
    ctl.riseNext   = cntN < (activeN >> 1);
    ctl.oddNext    = activeN[0];
    ctl.bypassNext = activeN < Two;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= DefLast;
      active  <= DefVal;
      pending <= DefVal;
    end else begin
      cnt     <= cntN;
      active  <= activeN;
      pending <= pendingN;
    end
  end

  // R4: a strobe captures the presented divisor
  assert_capture_R4: assert property (@(posedge refClk) disable iff (!rstN)
    load |=> pending == $past(newDiv));

  // R5: the running divisor changes only where a new period starts
  assert_switch_at_start_R5: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable(active) |-> cnt == '0);

  // R2: the period counter never passes the running divisor
  assert_count_range_R2: assert property (@(posedge refClk) disable iff (!rstN)
    (active >= Two) |-> cnt < active);
endmodule

// File: rtl/div_path.sv
module div_path import div_pkg::*; (
  input  logic     refClk,
  input  logic     rstN,
  input  div_ctl_t ctl,
  output logic     divOut
);
  logic riseQ, oddQ, bypassQ, fallQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      riseQ   <= 1'b0;
      oddQ    <= 1'b0;
      bypassQ <= 1'b0;
    end else begin
      riseQ   <= ctl.riseNext;
      oddQ    <= ctl.oddNext;
      bypassQ <= ctl.bypassNext;
    end
  end

  // Half-cycle extension for odd ratios: rising phase retimed on the falling edge
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) fallQ <= 1'b0;
    else       fallQ <= riseQ;
  end

  assign divOut = bypassQ ? refClk : (riseQ | (oddQ & fallQ));

  // R3: parity changes only as a fresh high phase begins
  assert_odd_align_R3: assert property (@(posedge refClk) disable iff (!rstN)
    (!$stable(oddQ) && !bypassQ) |-> riseQ);
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider #(
  parameter int DIV_W = 8,
  parameter int DEF_A = 15,
  parameter int DEF_B = 46
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divB,
  output logic             outA,
  output logic             outB
);
  import div_pkg::*;
  localparam int NCH = 2;

  logic [NCH-1:0][DIV_W-1:0] divIn;
  logic [NCH-1:0]            chOut;

  assign divIn = {divB, divA};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    div_ctl_t ctl;
    div_ctrl #(.W(DIV_W), .DEF(ch == 0 ? DEF_A : DEF_B)) u_ctrl (
      .refClk(refClk), .rstN(rstN), .load(loadStrobe),
      .newDiv(divIn[ch]), .ctl(ctl));
    div_path u_path (
      .refClk(refClk), .rstN(rstN), .ctl(ctl), .divOut(chOut[ch]));
  end

  assign outA = chOut[0];
  assign outB = chOut[1];
endmodule

// File: tb/sim_dual_clk_divider.sv
module sim_dual_clk_divider;
  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [7:0] divA = 8'd0, divB = 8'd0;
  logic       outA, outB;

  int    checks = 0, fails = 0;
  string tag = "R1";
  int    act [2];
  int    pend[2];
  int    cyc [2];

  dual_clk_divider u0 (.refClk(refClk), .rstN(rstN), .loadStrobe(loadStrobe),
                       .divA(divA), .divB(divB), .outA(outA), .outB(outB));

  always #4 refClk = ~refClk;  // 125 MHz

  // Behavioural model: divisor state and position inside the current period
  task automatic modelRise();
    for (int ch = 0; ch < 2; ch++) begin
      int nv = (ch == 0) ? int'(divA) : int'(divB);
      if (loadStrobe) pend[ch] = nv;
      if (act[ch] < 2 || cyc[ch] == act[ch] - 1) begin
        cyc[ch] = 0;
        act[ch] = pend[ch];
      end else cyc[ch]++;
    end
  endtask

  // half: 0 = after rising edge, 1 = after falling edge
  function automatic logic expected(int ch, int half);
    if (act[ch] < 2) return (half == 0);
    return (2 * cyc[ch] + half) < act[ch];
  endfunction

  task automatic compare(int half);
    for (int ch = 0; ch < 2; ch++) begin
      logic got = (ch == 0) ? outA : outB;
      logic exp = expected(ch, half);
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s ch%0d div=%0d pos=%0d half=%0d actual=%b expected=%b",
                 tag, ch, act[ch], cyc[ch], half, got, exp);
      end
    end
  endtask

  task automatic cycle();
    @(posedge refClk); #2;
    modelRise();
    compare(0);
    @(negedge refClk); #2;
    compare(1);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic loadPair(int a, int b);
    divA = 8'(a); divB = 8'(b); loadStrobe = 1'b1;
    cycle();
    loadStrobe = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    act[0] = 15; pend[0] = 15; cyc[0] = 14;
    act[1] = 46; pend[1] = 46; cyc[1] = 45;
    // R1: outputs low in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge refClk); #2;
      checks += 2;
      if (outA !== 1'b0 || outB !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset actual=%b%b expected=00", outA, outB);
      end
    end
    rstN = 1'b1;
    tag = "R1"; run(100);          // defaults 15 and 46
    tag = "R2"; loadPair(2, 46); run(60);
    tag = "R3"; loadPair(3, 15); run(90);
    tag = "R7"; loadPair(46, 15); run(120);
    tag = "R5"; loadPair(9, 46); run(3);
    loadPair(5, 46); run(20);      // overwrite before use
    tag = "R5"; loadPair(2, 3); run(1); loadPair(4, 7); run(30);
    tag = "R6"; loadPair(1, 0); run(20);
    tag = "R6"; loadPair(4, 7); run(40);
    tag = "R6"; loadPair(0, 3); run(20);
    tag = "R2"; loadPair(46, 2); run(100);
    tag = "R3"; loadPair(15, 3); run(50);
    summary();
  end
endmodule